// File: doc/BRIEF.md
# Serial Control Port Slave with Command Gating

This block is the two-wire serial front end of a single-channel DAC. It oversamples the SCL and SDA bus lines with the system clock. It finds START, repeated START and STOP conditions and recognises its own 7-bit device address. It also recognises a shared group address, so one command can reach every DAC on the bus at the same time.

Write transfers carry one or more command groups. Each group is a command byte followed by a 16-bit data word, sent high byte first. When a group is complete, the block raises a one-cycle strobe that carries the command byte and the data word. Read transfers return a 16-bit word, high byte first, that the register file supplies. The register file picks the word using the last command byte received. SDA is driven through an open-drain output enable.

A level input, `hold_req`, marks a gating condition. A gated command sent while this condition is active has its command byte acknowledged. Its two data bytes are left unacknowledged, which tells the master the command is being dropped, and no strobe is issued. Commands that are not gated keep working normally.

Top module: `dac_i2c_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, `cmd_valid` is 0, and the slave waits for a START.
- R2: An address byte carrying the device address (either R/W value) is acknowledged. The slave pulls SDA low (`sda_oe`=1) during the ninth SCL high phase.
- R3: Any other address is not acknowledged. SDA then stays released for every later byte until the next START, and no strobe is issued.
- R4: In a write, the bytes after the address repeat as a command byte, a data high byte and a data low byte. After the eighth bit of each low byte, `cmd_valid` pulses for exactly one clock with `cmd_byte` and `cmd_data`={high,low}. Several groups may follow one another in a single transfer.
- R5: Gated commands are those with a command-byte upper nibble of 1, 2 or 3. While gating is active, a gated command byte is acknowledged, both of its data bytes are not, and no strobe follows. Every strobe coincides with an acknowledge being driven.
- R6: Commands that are not gated are fully acknowledged and strobed even while gating is active, including inside the same transfer as a dropped command.
- R7: At every START and repeated START, gating takes the current value of `hold_req`. Releasing `hold_req` in the middle of a transfer has no effect until the next START. Asserting it in the middle of a transfer gates every command byte received afterwards.
- R8: A write to the group address is acknowledged. Only the load command (upper nibble 4) is executed from it, with `cmd_bcast`=1. Any other command there gets its command byte acknowledged, its data bytes not acknowledged, and no strobe. A read to the group address is not acknowledged.
- R9: After a read address is acknowledged, the slave sends `rd_word[15:8]` and then `rd_word[7:0]`, alternating, MSB first. It raises `sda_oe` only while SCL is low. A master ACK continues the read. A master NACK releases SDA until the next START.
- R10: `rd_cmd` holds the most recent command byte received and is used to select the read word.
- R11: A STOP releases SDA and returns the slave to idle. Bytes clocked after it without a new START are ignored and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| hold_req | input | 1 | Gating condition, active high |
| rd_cmd | output | 8 | Last command byte received |
| rd_word | input | 16 | Read data chosen by `rd_cmd` |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_byte | output | 8 | Command byte of the strobe |
| cmd_data | output | 16 | Data word of the strobe |
| cmd_bcast | output | 1 | Strobe came from the group address |

## Verification
A behavioural bench model tracks the gating state and the expected strobes. It checks the SDA enable in every acknowledge slot and in every read bit. The first pattern is plain writes with gating off. This shows that gated opcodes run normally when no gate is present. Gating is then applied in four ways: held across START, released in the middle of a transfer, released before a repeated START, and raised in the middle of a transfer. Together these separate sampling at START from level-following behaviour. Further patterns cover mixed gated and non-gated groups, the group address with load and non-load commands, foreign addresses, reads ended by ACK and by NACK, and bytes clocked after a STOP. These show apart the per-byte acknowledge decision, the address filter and the return to idle.

// File: rtl/dac_i2c_pkg.sv
package dac_i2c_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } bus_state_t;

  typedef enum logic [1:0] {
    SLOT_CMD,
    SLOT_HI,
    SLOT_LO
  } wr_slot_t;

  localparam logic [3:0] OPC_GATED_FIRST = 4'h1;
  localparam logic [3:0] OPC_GATED_LAST  = 4'h3;
  localparam logic [3:0] OPC_LOAD        = 4'h4;

  function automatic logic opc_gated(input logic [BYTE_W-1:0] c);
    return (c[7:4] >= OPC_GATED_FIRST) && (c[7:4] <= OPC_GATED_LAST);
  endfunction

  function automatic logic opc_load(input logic [BYTE_W-1:0] c);
    return c[7:4] == OPC_LOAD;
  endfunction

endpackage

// File: rtl/dac_i2c_line_sync.sv
module dac_i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/dac_i2c_addr_match.sv
module dac_i2c_addr_match #(
  parameter logic [6:0] DEV_ADDR   = 7'h3A,
  parameter logic [6:0] BCAST_ADDR = 7'h0F
) (
  input  logic [7:0] addr_byte,
  output logic       hit,
  output logic       bcast_hit
);

  logic [6:0] addr;
  logic       rd;

  assign addr      = addr_byte[7:1];
  assign rd        = addr_byte[0];
  assign bcast_hit = (addr == BCAST_ADDR) && !rd;
  assign hit       = (addr == DEV_ADDR) || bcast_hit;

endmodule

// File: rtl/dac_i2c_cmd_class.sv
module dac_i2c_cmd_class
  import dac_i2c_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd,
  input  logic              gate,
  input  logic              bcast,
  output logic              drop
);

  logic gated_hit;
  logic group_reject;

  assign gated_hit    = opc_gated(cmd) && gate;
  assign group_reject = bcast && !opc_load(cmd);
  assign drop         = gated_hit || group_reject;

endmodule

// File: rtl/dac_i2c_slave.sv
module dac_i2c_slave
  import dac_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter logic [6:0] BCAST_ADDR  = 7'h0F,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              hold_req,
  output logic [BYTE_W-1:0] rd_cmd,
  input  logic [WORD_W-1:0] rd_word,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic [WORD_W-1:0] cmd_data,
  output logic              cmd_bcast
);

  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  dac_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  bus_state_t        state;
  wr_slot_t          slot;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] cmd_q;
  logic [BYTE_W-1:0] hi_q;
  logic              to_tx;
  logic              tx_sel;
  logic              bcast_q;
  logic              gate_q;
  logic              drop_q;
  logic              mack_q;

  logic              addr_hit, addr_bcast;
  logic              drop_now;
  logic              gate_now;
  logic [BYTE_W-1:0] tx_next;

  assign gate_now = gate_q | hold_req;
  assign tx_next  = tx_sel ? rd_word[BYTE_W-1:0] : rd_word[WORD_W-1:BYTE_W];

  dac_i2c_addr_match #(.DEV_ADDR(DEV_ADDR), .BCAST_ADDR(BCAST_ADDR)) u_addr (
    .addr_byte(rx_sh), .hit(addr_hit), .bcast_hit(addr_bcast)
  );

  dac_i2c_cmd_class u_class (
    .cmd(rx_sh), .gate(gate_now), .bcast(bcast_q), .drop(drop_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      slot      <= SLOT_CMD;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      cmd_q     <= '0;
      hi_q      <= '0;
      to_tx     <= 1'b0;
      tx_sel    <= 1'b0;
      bcast_q   <= 1'b0;
      gate_q    <= 1'b0;
      drop_q    <= 1'b0;
      mack_q    <= 1'b0;
      sda_oe    <= 1'b0;
      rd_cmd    <= '0;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
      cmd_data  <= '0;
      cmd_bcast <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (hold_req) gate_q <= 1'b1;
      if (start_ev) begin
        state   <= ST_ADDR;
        slot    <= SLOT_CMD;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
        drop_q  <= 1'b0;
        gate_q  <= hold_req;
      end else if (stop_ev) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_RX: begin
            if (scl_rise && bit_cnt != LAST_BIT) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end
            if (scl_fall && bit_cnt == LAST_BIT) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  state   <= ST_ACK;
                  sda_oe  <= 1'b1;
                  to_tx   <= rx_sh[0];
                  tx_sel  <= 1'b0;
                  bcast_q <= addr_bcast;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                state <= ST_ACK;
                to_tx <= 1'b0;
                unique case (slot)
                  SLOT_CMD: begin
                    cmd_q  <= rx_sh;
                    rd_cmd <= rx_sh;
                    drop_q <= drop_now;
                    sda_oe <= 1'b1;
                    slot   <= SLOT_HI;
                  end
                  SLOT_HI: begin
                    hi_q   <= rx_sh;
                    sda_oe <= !drop_q;
                    slot   <= SLOT_LO;
                  end
                  default: begin
                    sda_oe <= !drop_q;
                    slot   <= SLOT_CMD;
                    if (!drop_q) begin
                      cmd_valid <= 1'b1;
                      cmd_byte  <= cmd_q;
                      cmd_data  <= {hi_q, rx_sh};
                      cmd_bcast <= bcast_q;
                    end
                  end
                endcase
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (to_tx) begin
                state   <= ST_TX;
                tx_sh   <= tx_next;
                sda_oe  <= ~tx_next[BYTE_W-1];
                tx_sel  <= ~tx_sel;
                bit_cnt <= '0;
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise && bit_cnt != LAST_BIT) bit_cnt <= bit_cnt + 4'd1;
            if (scl_fall) begin
              if (bit_cnt == LAST_BIT) begin
                state   <= ST_MACK;
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
              end else begin
                sda_oe <= ~tx_sh[BYTE_W-2];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) mack_q <= ~sda_s;
            if (scl_fall) begin
              if (mack_q) begin
                state  <= ST_TX;
                tx_sh  <= tx_next;
                sda_oe <= ~tx_next[BYTE_W-1];
                tx_sel <= ~tx_sel;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4: strobe lasts one clock
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R5: an executed command is always acknowledged on its last byte
  assert_strobe_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> sda_oe);

  // R8: the group address only ever yields a load strobe
  assert_bcast_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_bcast) |-> opc_load(cmd_byte));

  // R9: SDA is only pulled low while SCL is low
  assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R11: STOP releases the line
  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R3: idle never drives the bus
  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

endmodule

// File: tb/dac_i2c_slave_test.sv
`timescale 1ns/1ps
module dac_i2c_slave_test;

  localparam logic [6:0] DEV = 7'h3A;
  localparam logic [6:0] BC  = 7'h0F;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic hold = 1'b0;
  logic sda_oe, cmd_valid, cmd_bcast;
  logic [7:0] rd_cmd, cmd_byte;
  logic [15:0] rd_word, cmd_data;
  logic sda_line;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign rd_word  = {rd_cmd, ~rd_cmd};

  dac_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .hold_req(hold), .rd_cmd(rd_cmd), .rd_word(rd_word),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_data(cmd_data),
    .cmd_bcast(cmd_bcast)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  bit m_gate = 1'b0;
  logic [24:0] exp_q[$];
  logic [24:0] obs_q[$];

  always @(posedge clk) if (rst_n && cmd_valid) obs_q.push_back({cmd_bcast, cmd_byte, cmd_data});

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq(Q);
    m_gate = hold;
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    m_gate = hold;
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2 * Q);
    check(sda_oe == 1'b0, "R11 release at STOP", sda_oe, 0);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q / 2);
    check(sda_oe == exp_ack, req, sda_oe, exp_ack);
    wq(Q / 2);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic read_byte(input logic [7:0] expb, input bit ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl_m = 1'b1; wq(Q);
      check(sda_oe == ~expb[i], req, sda_oe, ~expb[i]);
      wq(Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = ack ? 1'b0 : 1'b1; wq(Q);
    scl_m = 1'b1; wq(2 * Q);
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic xfer(input logic [7:0] c, input logic [15:0] d, input bit bc, input string req);
    bit gated;
    bit drop;
    gated = (c[7:4] >= 4'h1) && (c[7:4] <= 4'h3);
    drop  = (gated && m_gate) || (bc && c[7:4] != 4'h4);
    send_byte(c, 1'b1, {req, " command ack"});
    send_byte(d[15:8], !drop, {req, " data high ack"});
    send_byte(d[7:0], !drop, {req, " data low ack"});
    if (!drop) exp_q.push_back({bc, c, d});
  endtask

  task automatic check_strobes(input string req);
    wq(2);
    check(obs_q.size() == exp_q.size(), {req, " strobe count"}, obs_q.size(), exp_q.size());
    if (obs_q.size() == exp_q.size())
      foreach (exp_q[k]) check(obs_q[k] == exp_q[k], {req, " strobe content"}, obs_q[k], exp_q[k]);
    obs_q.delete();
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    wq(5);
    check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    check(cmd_valid == 1'b0, "R1 reset strobe", cmd_valid, 0);
    rst_n = 1'b1; wq(5);

    // R2 R4: plain writes, gated opcode runs while no gate is present
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2 address ack");
    xfer(8'h51, 16'hA5C3, 1'b0, "R4");
    xfer(8'h23, 16'h0102, 1'b0, "R4");
    bus_stop();
    check_strobes("R4");

    // R5 R6: gate held, gated dropped, non-gated executed
    hold = 1'b1;
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2 address ack");
    xfer(8'h12, 16'h1111, 1'b0, "R5");
    xfer(8'h60, 16'h2222, 1'b0, "R6");
    bus_stop();
    check_strobes("R6");

    // R7: release mid-transfer waits for the repeated START
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2 address ack");
    hold = 1'b0;
    xfer(8'h31, 16'h4444, 1'b0, "R7 latched");
    bus_rstart();
    send_byte({DEV, 1'b0}, 1'b1, "R2 address ack");
    xfer(8'h32, 16'h3333, 1'b0, "R7 cleared");
    bus_stop();
    check_strobes("R7");

    // R7: raising the gate mid-transfer
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2 address ack");
    hold = 1'b1; m_gate = 1'b1;
    xfer(8'h13, 16'h5555, 1'b0, "R7 raised");
    hold = 1'b0;
    bus_stop();
    check_strobes("R7");

    // R3: foreign address
    bus_start();
    send_byte({7'h3B, 1'b0}, 1'b0, "R3 address nack");
    send_byte(8'h51, 1'b0, "R3 ignored byte");
    send_byte(8'h00, 1'b0, "R3 ignored byte");
    bus_stop();
    check_strobes("R3");

    // R8: group address
    bus_start();
    send_byte({BC, 1'b0}, 1'b1, "R8 group ack");
    xfer(8'h40, 16'h00FF, 1'b1, "R8 load");
    xfer(8'h51, 16'h7777, 1'b1, "R8 non-load");
    bus_stop();
    check_strobes("R8");
    bus_start();
    send_byte({BC, 1'b1}, 1'b0, "R8 group read nack");
    bus_stop();

    // R9 R10: read back
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2 address ack");
    send_byte(8'h73, 1'b1, "R10 command ack");
    bus_rstart();
    send_byte({DEV, 1'b1}, 1'b1, "R9 read address ack");
    check(rd_cmd == 8'h73, "R10 rd_cmd", rd_cmd, 8'h73);
    read_byte(8'h73, 1'b1, "R9 high byte");
    read_byte(8'h8C, 1'b1, "R9 low byte");
    read_byte(8'h73, 1'b0, "R9 wrap byte");
    wq(Q);
    check(sda_oe == 1'b0, "R9 release after nack", sda_oe, 0);
    bus_stop();
    check_strobes("R9");

    // R11: bytes after STOP are ignored
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2 address ack");
    send_byte(8'h51, 1'b1, "R11 command ack");
    bus_stop();
    scl_m = 1'b0; wq(Q);
    send_byte(8'h80, 1'b0, "R11 idle byte");
    send_byte(8'h01, 1'b0, "R11 idle byte");
    scl_m = 1'b1; wq(2 * Q);
    check_strobes("R11");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule